// File: doc/BRIEF.md
# Condition Code and Interrupt Mask Unit

This block holds the flag byte of a small accumulator CPU: half-carry (H), interrupt mask (I), negative (N), zero (Z) and carry (C). The three upper bits of the byte always read as one. Each cycle the decoder presents an operation class together with the ALU result, its carry-out and bit `HALF_POS` of both operands. The unit updates only the flags that belong to that class. An RTI strobe reloads the whole byte from the value pulled off the stack.

The unit also runs the interrupt mask sequence. A request that arrives while the mask is set is held in a pending latch. It is accepted at the first instruction boundary with the mask clear. On acceptance the unit captures the current flag byte as the image to be stacked. The mask goes high when the CPU reports that stacking is done, which is before the vector fetch. No second request is accepted until that vector fetch has happened.

Bit layout, MSB first: 1, 1, 1, H, I, N, Z, C. Operation class codes: 0 none, 1 add (ADD/ADC), 2 subtract/compare, 3 shift, 4 logical, 5 load, 6 data manipulation, 7 none.

Top module: `ccr_unit`

## Requirements
- R1: `ccrOut[7:5]` and `stackImage[7:5]` always read 3'b111, even after a restore from a byte whose upper bits are zero.
- R2: On an add (class 1), H takes the carry from bit HALF_POS-1 into bit HALF_POS (`opBitA ^ opBitB ^ result[HALF_POS]`), N takes result MSB, Z is set when the result is zero, and C takes `carryOut`.
- R3: H changes on no class except add, and otherwise only through an RTI restore.
- R4: Subtract/compare (2) and shift (3) update N, Z and C. Logical (4), load (5) and manipulation (6) update N and Z and leave C unchanged.
- R5: Classes 0 and 7 leave every flag unchanged.
- R6: Reset (`rstN` low) sets I and clears the pending latch and the entry sequence. H, N, Z and C keep their values across the reset.
- R7: I is set by `seiStb` or a stack-done strobe, and is cleared only by `cliStb` or `waitStb` (or by a restore). When a set and a clear arrive in the same cycle, the set wins.
- R8: A request seen while I is set is latched. It is taken at the first boundary after I clears, even if `irqReq` has since dropped.
- R9: `irqTake` is high only in a cycle with `boundary` high, I clear, and a request live or pending. Taking the request clears the pending latch.
- R10: On a take, `stackImage` captures the flag byte as it was in the take cycle, with I still clear. I is set by `stackDone`, so it is already high when `vecFetch` arrives.
- R11: `rtiStb` loads H, I, N, Z and C from `rtiByte[4:0]`, and this overrides any flag update or mask strobe in the same cycle.
- R12: From a take until the following `vecFetch`, no further take occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 3 | Operation class of the current result |
| opBitA | input | 1 | Bit HALF_POS of the first ALU operand |
| opBitB | input | 1 | Bit HALF_POS of the second ALU operand |
| result | input | DATA_W | ALU result |
| carryOut | input | 1 | ALU carry/borrow out |
| cliStb | input | 1 | Clear-mask instruction strobe |
| waitStb | input | 1 | Wait instruction strobe (clears mask) |
| seiStb | input | 1 | Set-mask instruction strobe |
| stackDone | input | 1 | Register stacking of interrupt entry finished |
| vecFetch | input | 1 | Interrupt vector fetch strobe |
| rtiStb | input | 1 | Return-from-interrupt restore strobe |
| rtiByte | input | 8 | Flag byte pulled from the stack |
| irqReq | input | 1 | Interrupt request |
| boundary | input | 1 | Instruction boundary strobe |
| ccrOut | output | 8 | Readable flag byte |
| stackImage | output | 8 | Flag byte captured at interrupt acceptance |
| irqTake | output | 1 | Interrupt accepted this cycle |

## Verification
The bench builds the unit with its defaults, DATA_W = 8 and HALF_POS = 4. These values make the result sign bit, the zero test and the bit-3-to-4 half carry directly observable with byte-sized test values. A behavioural model compares every cycle. Directed stretches cover each class, the mid-run reset, a request latched under the mask, and a restore that collides with an add. A protocol-respecting random phase then mixes requests, boundaries and strobes.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_SHIFT = 3'd3,
    OP_LOGIC = 3'd4,
    OP_LOAD  = 3'd5,
    OP_MANIP = 3'd6,
    OP_IDLE7 = 3'd7
  } opClass_e;

  typedef struct packed {
    logic setMask;
    logic clrMask;
    logic restore;
    logic snap;
  } ccrCtl_t;

  localparam int CCR_W = 8;
  localparam int C_POS = 0;
  localparam int Z_POS = 1;
  localparam int N_POS = 2;
  localparam int I_POS = 3;
  localparam int H_POS = 4;
endpackage

// File: rtl/ccr_ctl.sv
module ccr_ctl
  import ccr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    maskNow,
  input  logic    irqReq,
  input  logic    boundary,
  input  logic    stackDone,
  input  logic    vecFetch,
  input  logic    cliStb,
  input  logic    waitStb,
  input  logic    seiStb,
  input  logic    rtiStb,
  output ccrCtl_t ctl,
  output logic    irqTake
);
  typedef enum logic [1:0] {PH_IDLE, PH_STACK, PH_VEC} entryPhase_e;

  entryPhase_e phase;
  logic        pending;
  logic        reqLive;

  always_comb begin
    reqLive     = pending | irqReq;
    irqTake     = boundary & ~maskNow & reqLive & (phase == PH_IDLE);
    ctl.snap    = irqTake;
    ctl.restore = rtiStb;
    ctl.setMask = seiStb | (stackDone & (phase == PH_STACK));
    ctl.clrMask = cliStb | waitStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      phase   <= PH_IDLE;
    end else begin
      pending <= reqLive & ~irqTake;
      unique case (phase)
        PH_IDLE:  if (irqTake)   phase <= PH_STACK;
        PH_STACK: if (stackDone) phase <= PH_VEC;
        PH_VEC:   if (vecFetch)  phase <= PH_IDLE;
        default:                 phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccr_dp.sv
module ccr_dp
  import ccr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_POS = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccrCtl_t           ctl,
  input  logic [2:0]        opCode,
  input  logic              opBitA,
  input  logic              opBitB,
  input  logic [DATA_W-1:0] result,
  input  logic              carryOut,
  input  logic [CCR_W-1:0]  rtiByte,
  output logic [CCR_W-1:0]  ccrOut,
  output logic [CCR_W-1:0]  stackImage,
  output logic              maskNow
);
  localparam int MSB = DATA_W - 1;
  localparam logic [CCR_W-1:0] STACK_RST = 8'hE8;

  logic hFlag, nFlag, zFlag, cFlag, iFlag;
  logic halfCarry, resNeg, resZero;
  opClass_e opClass;

  always_comb begin
    opClass   = opClass_e'(opCode);
    halfCarry = opBitA ^ opBitB ^ result[HALF_POS];
    resNeg    = result[MSB];
    resZero   = (result == '0);
    maskNow   = iFlag;
    ccrOut    = {3'b111, hFlag, iFlag, nFlag, zFlag, cFlag};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                iFlag <= 1'b1;
    else if (ctl.restore)     iFlag <= rtiByte[I_POS];
    else if (ctl.setMask)     iFlag <= 1'b1;
    else if (ctl.clrMask)     iFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (ctl.restore) begin
      hFlag <= rtiByte[H_POS];
      nFlag <= rtiByte[N_POS];
      zFlag <= rtiByte[Z_POS];
      cFlag <= rtiByte[C_POS];
    end else begin
      unique case (opClass)
        OP_ADD: begin
          hFlag <= halfCarry;
          nFlag <= resNeg;
          zFlag <= resZero;
          cFlag <= carryOut;
        end
        OP_SUB, OP_SHIFT: begin
          nFlag <= resNeg;
          zFlag <= resZero;
          cFlag <= carryOut;
        end
        OP_LOGIC, OP_LOAD, OP_MANIP: begin
          nFlag <= resNeg;
          zFlag <= resZero;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         stackImage <= STACK_RST;
    else if (ctl.snap) stackImage <= ccrOut;
  end
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_POS = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic              opBitA,
  input  logic              opBitB,
  input  logic [DATA_W-1:0] result,
  input  logic              carryOut,
  input  logic              cliStb,
  input  logic              waitStb,
  input  logic              seiStb,
  input  logic              stackDone,
  input  logic              vecFetch,
  input  logic              rtiStb,
  input  logic [7:0]        rtiByte,
  input  logic              irqReq,
  input  logic              boundary,
  output logic [7:0]        ccrOut,
  output logic [7:0]        stackImage,
  output logic              irqTake
);
  ccrCtl_t ctl;
  logic    maskNow;

  ccr_ctl u_ctl (
    .clk(clk), .rstN(rstN), .maskNow(maskNow), .irqReq(irqReq),
    .boundary(boundary), .stackDone(stackDone), .vecFetch(vecFetch),
    .cliStb(cliStb), .waitStb(waitStb), .seiStb(seiStb), .rtiStb(rtiStb),
    .ctl(ctl), .irqTake(irqTake)
  );

  ccr_dp #(.DATA_W(DATA_W), .HALF_POS(HALF_POS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opCode(opCode),
    .opBitA(opBitA), .opBitB(opBitB), .result(result),
    .carryOut(carryOut), .rtiByte(rtiByte), .ccrOut(ccrOut),
    .stackImage(stackImage), .maskNow(maskNow)
  );
endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] opCode,
  input logic       cliStb,
  input logic       waitStb,
  input logic       rtiStb,
  input logic [7:0] rtiByte,
  input logic       boundary,
  input logic       vecFetch,
  input logic [7:0] ccrOut,
  input logic [7:0] stackImage,
  input logic       irqTake
);
  logic inEntry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         inEntry <= 1'b0;
    else if (irqTake)  inEntry <= 1'b1;
    else if (vecFetch) inEntry <= 1'b0;
  end

  // R1
  upper_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ccrOut[7:5] == 3'b111) && (stackImage[7:5] == 3'b111));

  // R3
  h_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode != 3'd1 && !rtiStb) |=> $stable(ccrOut[4]));

  // R7
  mask_clear_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ccrOut[3]) |-> $past(cliStb || waitStb || rtiStb));

  // R9
  take_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |-> (boundary && !ccrOut[3]));

  // R10
  vec_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecFetch && inEntry) |-> ccrOut[3]);

  // R11
  restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    rtiStb |=> (ccrOut[4:0] == $past(rtiByte[4:0])));

  // R12
  no_reentry_chk: assert property (@(posedge clk) disable iff (!rstN)
    inEntry |-> !irqTake);
endmodule

bind ccr_unit ccr_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .opCode(opCode), .cliStb(cliStb),
  .waitStb(waitStb), .rtiStb(rtiStb), .rtiByte(rtiByte),
  .boundary(boundary), .vecFetch(vecFetch), .ccrOut(ccrOut),
  .stackImage(stackImage), .irqTake(irqTake)
);

// File: tb/tb_ccr_unit.sv
`timescale 1ns/1ps
module tb_ccr_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] opCode = 3'd0;
  logic       opBitA = 1'b0, opBitB = 1'b0;
  logic [7:0] result = 8'h00;
  logic       carryOut = 1'b0;
  logic       cliStb = 1'b0, waitStb = 1'b0, seiStb = 1'b0;
  logic       stackDone = 1'b0, vecFetch = 1'b0, rtiStb = 1'b0;
  logic [7:0] rtiByte = 8'h00;
  logic       irqReq = 1'b0, boundary = 1'b0;
  logic [7:0] ccrOut, stackImage;
  logic       irqTake;

  int errors = 0, checks = 0;
  int mH = 0, mI = 1, mN = 0, mZ = 0, mC = 0;
  int mPend = 0, mPhase = 0;
  int mStk = 8'hE8;
  bit known = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ccr_unit dut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .opBitA(opBitA), .opBitB(opBitB),
    .result(result), .carryOut(carryOut), .cliStb(cliStb), .waitStb(waitStb),
    .seiStb(seiStb), .stackDone(stackDone), .vecFetch(vecFetch),
    .rtiStb(rtiStb), .rtiByte(rtiByte), .irqReq(irqReq), .boundary(boundary),
    .ccrOut(ccrOut), .stackImage(stackImage), .irqTake(irqTake)
  );

  function automatic int modelByte();
    return 8'hE0 | (mH << 4) | (mI << 3) | (mN << 2) | (mZ << 1) | mC;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clr();
    opCode = 3'd0; opBitA = 0; opBitB = 0; result = 8'h00; carryOut = 0;
    cliStb = 0; waitStb = 0; seiStb = 0; stackDone = 0; vecFetch = 0;
    rtiStb = 0; rtiByte = 8'h00; irqReq = 0; boundary = 0;
  endtask

  task automatic compareOut(input string tag);
    int msk = known ? 8'hFF : 8'hE8;
    int exp = modelByte();
    check((int'(ccrOut) & msk) == (exp & msk), tag, ccrOut, exp);
    check(int'(stackImage) == mStk, {tag, " stack"}, stackImage, mStk);
  endtask

  // Inputs are set by the caller at a negedge; one clock is applied.
  task automatic step(input string tag);
    int take, nI, hc, neg, zer;
    #1;
    take = (boundary && !mI && (mPend || irqReq) && mPhase == 0) ? 1 : 0;
    check(int'(irqTake) == take, {tag, " take"}, irqTake, take);
    hc = opBitA ^ opBitB ^ result[4];
    neg = result[7];
    zer = (result == 8'h00) ? 1 : 0;
    if (take) mStk = modelByte();
    nI = mI;
    if (rtiStb) nI = rtiByte[3];
    else if (seiStb || (stackDone && mPhase == 1)) nI = 1;
    else if (cliStb || waitStb) nI = 0;
    if (rtiStb) begin
      mH = rtiByte[4]; mN = rtiByte[2]; mZ = rtiByte[1]; mC = rtiByte[0];
    end else begin
      case (opCode)
        3'd1: begin mH = hc; mN = neg; mZ = zer; mC = carryOut; known = 1; end
        3'd2, 3'd3: begin mN = neg; mZ = zer; mC = carryOut; end
        3'd4, 3'd5, 3'd6: begin mN = neg; mZ = zer; end
        default: ;
      endcase
    end
    mI = nI;
    mPend = ((mPend || irqReq) && !take) ? 1 : 0;
    if (mPhase == 0 && take) mPhase = 1;
    else if (mPhase == 1 && stackDone) mPhase = 2;
    else if (mPhase == 2 && vecFetch) mPhase = 0;
    @(posedge clk);
    @(negedge clk);
    compareOut(tag);
    clr();
  endtask

  task automatic doReset(input string tag);
    rstN = 0;
    mI = 1; mPend = 0; mPhase = 0; mStk = 8'hE8;
    @(negedge clk);
    @(negedge clk);
    compareOut(tag);
    rstN = 1;
  endtask

  task automatic aluOp(input int code, input int a4, input int b4,
                       input int res, input int cy, input string tag);
    opCode = 3'(code); opBitA = 1'(a4); opBitB = 1'(b4);
    result = 8'(res); carryOut = 1'(cy);
    step(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clr();
    @(negedge clk);
    doReset("R6 reset state R1");
    // R2 add flags: 0x08+0x08=0x10 -> H=1
    aluOp(1, 0, 0, 8'h10, 0, "R2 add half carry");
    aluOp(1, 0, 0, 8'h00, 1, "R2 add zero carry");
    aluOp(1, 1, 0, 8'h80, 0, "R2 add negative");
    // R3 R4 subtract keeps H
    aluOp(2, 1, 0, 8'hF0, 1, "R4 sub R3");
    aluOp(3, 0, 0, 8'h00, 1, "R4 shift R3");
    aluOp(4, 1, 1, 8'h80, 0, "R4 logic keeps C");
    aluOp(5, 0, 1, 8'h00, 0, "R4 load keeps C");
    aluOp(6, 0, 0, 8'h7F, 0, "R4 manip");
    aluOp(0, 1, 0, 8'h00, 1, "R5 none class 0");
    aluOp(7, 1, 1, 8'h80, 1, "R5 none class 7");
    // R6 mid-run reset keeps flags
    cliStb = 1; step("R7 cli");
    doReset("R6 flags kept");
    // R7 clear sources and priority
    seiStb = 1; cliStb = 1; step("R7 set beats clear");
    waitStb = 1; step("R7 wait clears");
    seiStb = 1; step("R7 sei sets");
    // R8 request under mask latched
    irqReq = 1; step("R8 latch");
    boundary = 1; step("R8 masked no take");
    cliStb = 1; step("R8 cli");
    aluOp(1, 0, 0, 8'h10, 0, "R2 prepare flags");
    boundary = 1; step("R8 R9 take pending");
    // R10 entry sequence, R12 no re-entry
    irqReq = 1; boundary = 1; step("R12 stacking no take");
    stackDone = 1; step("R10 stack done sets mask");
    vecFetch = 1; step("R10 vector fetch");
    boundary = 1; step("R9 pending cleared");
    // R11 restore overrides add
    rtiStb = 1; rtiByte = 8'h07; opCode = 3'd1; result = 8'h80; carryOut = 0;
    step("R11 restore R1");
    boundary = 1; irqReq = 1; step("R9 live take");
    stackDone = 1; step("R10 mask");
    vecFetch = 1; step("R10 fetch");
    rtiStb = 1; rtiByte = 8'h10; step("R11 restore mask clear");
    // random phase
    for (int k = 0; k < 2000; k++) begin
      int r = $urandom_range(0, 99);
      opCode = 3'($urandom_range(0, 7));
      result = 8'($urandom);
      opBitA = 1'($urandom); opBitB = 1'($urandom);
      carryOut = 1'($urandom);
      irqReq = ($urandom_range(0, 9) == 0);
      boundary = ($urandom_range(0, 2) == 0);
      if (mPhase == 1) stackDone = ($urandom_range(0, 2) == 0);
      else if (mPhase == 2) vecFetch = ($urandom_range(0, 2) == 0);
      else begin
        if (r < 8) cliStb = 1;
        else if (r < 12) waitStb = 1;
        else if (r < 18) seiStb = 1;
        else if (r < 22) begin rtiStb = 1; rtiByte = 8'($urandom); end
      end
      step("R2 R4 R8 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule